// File: doc/BRIEF.md
# Per-Zone Access Rights Checker

This block decides, for each read or write request aimed at one of the user data zones of a secure serial memory, whether the request may proceed. It also decides how a granted write may change each bit of the stored byte. Each zone has an 8-bit access byte, and all of them enter on one flattened input. The request names its zone, and the checker selects that zone's access byte.

The checker combines the selected access byte with four more inputs: the personalization fuse, the currently verified password (its set number and its kind), and the authentication status. From these it forms a read grant, a write grant, a per-bit write mask, and the byte that would be stored. Every control bit in the access byte is active-low: a field whose bit is 0 is enabled.

The response is registered and appears one clock after the request. The surrounding memory controller uses the grants to gate its array access. It uses the mask and the store byte to carry out program-only writes, which may only clear bits.

Top module: `zone_acc_top`

## Requirements
- R1: Access byte layout, with each control bit enabled when it is 0: bit 7 is write-password-enable, bit 6 is read-password-enable, bit 5 is authentication-enable, bits 4..2 are the password set number, bit 1 is modify-forbid, and bit 0 is program-only. The byte for zone z sits at accessRegs[8z+7:8z]. With every control bit at 1, personalization done and no password verified, both reads and writes are granted.
- R2: The response (respValid, readAllow, writeAllow, writeMask, storeByte) appears on the clock edge after the request cycle. A cycle with reqValid=0 gives respValid=0, both grants 0, writeMask=0 and storeByte=0. readAllow can only be 1 for a read request (reqWrite=0), and writeAllow can only be 1 for a write request (reqWrite=1).
- R3: When bit 6 is 0, a read is granted only if the verified password belongs to the zone's set (pwValid=1 and pwSet equals bits 4..2). The password may be of either kind (pwIsWrite 0 or 1). When bit 6 is 1, reads need no password.
- R4: When bit 7 is 0, a write is granted only if a write password (pwIsWrite=1) of the zone's set is verified. A verified read password of that set is not enough. When bit 7 is 1 and personalization is done, writes need no password.
- R5: While persoPending=1, a write needs the verified write password of the zone's set even when bit 7 is 1.
- R6: When bit 5 is 0 and authOk=0, both reads and writes are denied whatever the password state.
- R7: When bit 1 is 0, every write is denied. Reads of that zone are unaffected.
- R8: On a granted write with bit 0 = 0 (program-only), writeMask equals oldByte and storeByte = oldByte AND newByte. With bit 0 = 1, writeMask is all ones and storeByte = newByte.
- R9: On a request that is not a granted write, writeMask is 0 and storeByte equals oldByte. This includes any read, and a program-only zone whose write is also forbidden.
- R10: A single verified password opens every zone whose set field matches it. It opens no zone whose set field differs.
- R11: While rstN=0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqZone | input | ZONE_W | Zone number of the request |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| accessRegs | input | NUM_ZONES*8 | Access bytes of all zones, zone z at bits 8z+7..8z |
| persoPending | input | 1 | Personalization fuse still intact (1) |
| pwValid | input | 1 | A password is currently verified |
| pwSet | input | 3 | Set number of the verified password |
| pwIsWrite | input | 1 | Verified password is the write password of its set |
| authOk | input | 1 | Authentication currently held |
| oldByte | input | 8 | Byte presently stored at the target address |
| newByte | input | 8 | Byte the host wants to write |
| respValid | output | 1 | Response for the previous cycle's request |
| readAllow | output | 1 | Read granted |
| writeAllow | output | 1 | Write granted |
| writeMask | output | 8 | Bits the write may replace with newByte |
| storeByte | output | 8 | Byte to be stored after masking |

## Verification
Modify-forbid and program-only can both act on one write, and so can the forced write-password check and an enabled password bit. Zone 7 sets both modify-forbid and program-only, and the bench writes to it with a nonzero old byte. The bench expects the forbid to win, so it looks for a zero mask and an unchanged store byte. Writes to a fully open zone while persoPending=1, with and without a matching write password, show whether the forced check alone decides the write grant. A behavioural reference model in the bench judges every cycle, including several hundred random cycles.

// File: rtl/zone_acc_pkg.sv
package zone_acc_pkg;
  localparam int ACC_W   = 8;
  localparam int SET_W   = 3;
  localparam int BIT_WPE = 7;
  localparam int BIT_RPE = 6;
  localparam int BIT_ATE = 5;
  localparam int SET_LSB = 2;
  localparam int BIT_MDF = 1;
  localparam int BIT_PGO = 0;

  typedef struct packed {
    logic respond;
    logic grantRead;
    logic grantWrite;
    logic progOnly;
  } accStrobe_t;
endpackage

// File: rtl/zone_acc_ctrl.sv
module zone_acc_ctrl
  import zone_acc_pkg::*;
(
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [ACC_W-1:0] selAcc,
  input  logic             persoPending,
  input  logic             pwValid,
  input  logic [SET_W-1:0] pwSet,
  input  logic             pwIsWrite,
  input  logic             authOk,
  output accStrobe_t       strobe
);
  logic setHit, authPass, readOk, wpNeeded, writeOk;

  always_comb begin
    setHit   = pwValid && (pwSet == selAcc[SET_LSB +: SET_W]);
    authPass = selAcc[BIT_ATE] || authOk;
    readOk   = authPass && (selAcc[BIT_RPE] || setHit);
    wpNeeded = !selAcc[BIT_WPE] || persoPending;
    writeOk  = authPass && selAcc[BIT_MDF] && (!wpNeeded || (setHit && pwIsWrite));
    strobe.respond    = reqValid;
    strobe.grantRead  = reqValid && !reqWrite && readOk;
    strobe.grantWrite = reqValid && reqWrite && writeOk;
    strobe.progOnly   = !selAcc[BIT_PGO];
  end

  // R5: forced write-password check while personalizing
  always_comb begin
    if (persoPending && !(pwValid && pwIsWrite))
      p_perso_force_r5: assert (!strobe.grantWrite)
        else $error("write granted during personalization without write password");
  end

  // R6: authentication gate
  always_comb begin
    if (!selAcc[BIT_ATE] && !authOk)
      p_auth_gate_r6: assert (!strobe.grantRead && !strobe.grantWrite)
        else $error("access granted without authentication");
  end
endmodule

// File: rtl/zone_acc_data.sv
module zone_acc_data
  import zone_acc_pkg::*;
#(
  parameter int NUM_ZONES = 8,
  parameter int DATA_W    = 8,
  localparam int ZONE_W   = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [ZONE_W-1:0]          reqZone,
  input  logic [NUM_ZONES*ACC_W-1:0] accessRegs,
  input  logic [DATA_W-1:0]          oldByte,
  input  logic [DATA_W-1:0]          newByte,
  input  accStrobe_t                 strobe,
  output logic [ACC_W-1:0]           selAcc,
  output logic                       respValid,
  output logic                       readAllow,
  output logic                       writeAllow,
  output logic [DATA_W-1:0]          writeMask,
  output logic [DATA_W-1:0]          storeByte
);
  logic [ACC_W-1:0]  zoneAcc [NUM_ZONES];
  logic [DATA_W-1:0] nextMask, nextStore;

  for (genvar g = 0; g < NUM_ZONES; g++) begin : g_unpack
    assign zoneAcc[g] = accessRegs[g*ACC_W +: ACC_W];
  end

  assign selAcc = zoneAcc[reqZone];

  always_comb begin
    if (!strobe.grantWrite)    nextMask = '0;
    else if (strobe.progOnly)  nextMask = oldByte;
    else                       nextMask = '1;
    nextStore = (oldByte & ~nextMask) | (newByte & nextMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.respond) begin
      respValid  <= 1'b0;
      readAllow  <= 1'b0;
      writeAllow <= 1'b0;
      writeMask  <= '0;
      storeByte  <= '0;
    end else begin
      respValid  <= 1'b1;
      readAllow  <= strobe.grantRead;
      writeAllow <= strobe.grantWrite;
      writeMask  <= nextMask;
      storeByte  <= nextStore;
    end
  end

  p_mdf_forbid_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !selAcc[BIT_MDF] |=> !writeAllow);

  p_grant_has_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    (readAllow || writeAllow) |-> respValid);

  p_prog_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grantWrite && strobe.progOnly |=> (storeByte & ~$past(oldByte)) == '0);

  p_deny_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !strobe.grantWrite |=> writeMask == '0 && storeByte == $past(oldByte));
endmodule

// File: rtl/zone_acc_top.sv
module zone_acc_top
  import zone_acc_pkg::*;
#(
  parameter int NUM_ZONES = 8,
  parameter int DATA_W    = 8,
  localparam int ZONE_W   = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [ZONE_W-1:0]          reqZone,
  input  logic                       reqWrite,
  input  logic [NUM_ZONES*ACC_W-1:0] accessRegs,
  input  logic                       persoPending,
  input  logic                       pwValid,
  input  logic [SET_W-1:0]           pwSet,
  input  logic                       pwIsWrite,
  input  logic                       authOk,
  input  logic [DATA_W-1:0]          oldByte,
  input  logic [DATA_W-1:0]          newByte,
  output logic                       respValid,
  output logic                       readAllow,
  output logic                       writeAllow,
  output logic [DATA_W-1:0]          writeMask,
  output logic [DATA_W-1:0]          storeByte
);
  accStrobe_t       strobe;
  logic [ACC_W-1:0] selAcc;

  zone_acc_ctrl u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .selAcc(selAcc),
    .persoPending(persoPending), .pwValid(pwValid), .pwSet(pwSet),
    .pwIsWrite(pwIsWrite), .authOk(authOk), .strobe(strobe)
  );

  zone_acc_data #(.NUM_ZONES(NUM_ZONES), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqZone(reqZone),
    .accessRegs(accessRegs), .oldByte(oldByte), .newByte(newByte),
    .strobe(strobe), .selAcc(selAcc), .respValid(respValid),
    .readAllow(readAllow), .writeAllow(writeAllow),
    .writeMask(writeMask), .storeByte(storeByte)
  );
endmodule

// File: tb/zone_acc_top_tb.sv
module zone_acc_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqZone = '0;
  logic        reqWrite = 1'b0;
  logic [63:0] accessRegs;
  logic        persoPending = 1'b0;
  logic        pwValid = 1'b0;
  logic [2:0]  pwSet = '0;
  logic        pwIsWrite = 1'b0;
  logic        authOk = 1'b0;
  logic [7:0]  oldByte = '0;
  logic [7:0]  newByte = '0;
  logic        respValid, readAllow, writeAllow;
  logic [7:0]  writeMask, storeByte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  zone_acc_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqZone(reqZone),
    .reqWrite(reqWrite), .accessRegs(accessRegs), .persoPending(persoPending),
    .pwValid(pwValid), .pwSet(pwSet), .pwIsWrite(pwIsWrite), .authOk(authOk),
    .oldByte(oldByte), .newByte(newByte), .respValid(respValid),
    .readAllow(readAllow), .writeAllow(writeAllow),
    .writeMask(writeMask), .storeByte(storeByte)
  );

  // behavioural reference: returns {respValid, readAllow, writeAllow, mask, store}
  function automatic logic [18:0] refModel();
    logic [7:0] acc;
    bit matched, okRead, okWrite;
    logic [7:0] m, s;
    if (!reqValid) return '0;
    acc = accessRegs[reqZone*8 +: 8];
    matched = pwValid && (int'(pwSet) == int'(acc[4:2]));
    okRead = 1; okWrite = 1;
    if (acc[5] == 1'b0 && !authOk) begin okRead = 0; okWrite = 0; end
    if (acc[6] == 1'b0 && !matched) okRead = 0;
    if ((acc[7] == 1'b0 || persoPending) && !(matched && pwIsWrite)) okWrite = 0;
    if (acc[1] == 1'b0) okWrite = 0;
    if (reqWrite) okRead = 0; else okWrite = 0;
    if (!okWrite) begin m = 8'h00; s = oldByte; end
    else if (acc[0] == 1'b0) begin m = oldByte; s = oldByte & newByte; end
    else begin m = 8'hFF; s = newByte; end
    return {1'b1, okRead, okWrite, m, s};
  endfunction

  task automatic compare(string tag, logic [18:0] exp);
    logic [18:0] act;
    act = {respValid, readAllow, writeAllow, writeMask, storeByte};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%05h exp=%05h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, int z, bit wr, bit perso, bit pv,
                      int ps, bit pw, bit au, logic [7:0] ob, logic [7:0] nb);
    logic [18:0] exp;
    reqValid = v; reqZone = 3'(z); reqWrite = wr; persoPending = perso;
    pwValid = pv; pwSet = 3'(ps); pwIsWrite = pw; authOk = au;
    oldByte = ob; newByte = nb;
    exp = refModel();
    @(negedge clk);
    compare(tag, exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // zones 7..0
    accessRegs = {8'hFC, 8'hDF, 8'hFE, 8'hFD, 8'h37, 8'h2B, 8'h2B, 8'hFF};
    reqValid = 1'b1; reqWrite = 1'b1; oldByte = 8'h5A; newByte = 8'hFF;
    repeat (3) @(negedge clk);
    compare("R11 reset", '0);
    rstN = 1'b1;
    // step(tag, valid, zone, wr, perso, pwV, pwSet, pwW, auth, old, new)
    step("R1 open write",       1, 0, 1, 0, 0, 0, 0, 0, 8'h12, 8'h34);
    step("R1 open read",        1, 0, 0, 0, 0, 0, 0, 0, 8'h12, 8'h34);
    step("R2 idle",             0, 0, 1, 0, 0, 0, 0, 0, 8'h12, 8'h34);
    step("R3 read no pw",       1, 1, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00);
    step("R3 read rd pw",       1, 1, 0, 0, 1, 2, 0, 0, 8'h00, 8'h00);
    step("R3 read wr pw",       1, 1, 0, 0, 1, 2, 1, 0, 8'h00, 8'h00);
    step("R4 write rd pw",      1, 1, 1, 0, 1, 2, 0, 0, 8'h33, 8'hC3);
    step("R4 write wr pw",      1, 1, 1, 0, 1, 2, 1, 0, 8'h33, 8'hC3);
    step("R4 write wrong set",  1, 1, 1, 0, 1, 3, 1, 0, 8'h33, 8'hC3);
    step("R10 shared zone2",    1, 2, 0, 0, 1, 2, 0, 0, 8'h00, 8'h00);
    step("R10 other set zone3", 1, 3, 0, 0, 1, 2, 0, 0, 8'h00, 8'h00);
    step("R10 own set zone3",   1, 3, 0, 0, 1, 5, 0, 0, 8'h00, 8'h00);
    step("R5 perso no pw",      1, 0, 1, 1, 0, 0, 0, 0, 8'h0F, 8'hF0);
    step("R5 perso wr pw",      1, 0, 1, 1, 1, 7, 1, 0, 8'h0F, 8'hF0);
    step("R5 perso rd pw",      1, 0, 1, 1, 1, 7, 0, 0, 8'h0F, 8'hF0);
    step("R6 read no auth",     1, 6, 0, 0, 1, 7, 1, 0, 8'h00, 8'h00);
    step("R6 write no auth",    1, 6, 1, 0, 1, 7, 1, 0, 8'h11, 8'h22);
    step("R6 read auth",        1, 6, 0, 0, 0, 0, 0, 1, 8'h00, 8'h00);
    step("R7 write forbid",     1, 4, 1, 0, 1, 7, 1, 1, 8'h44, 8'h55);
    step("R7 read allowed",     1, 4, 0, 0, 0, 0, 0, 0, 8'h44, 8'h55);
    step("R8 prog only",        1, 5, 1, 0, 0, 0, 0, 0, 8'hA5, 8'h0F);
    step("R8 prog only set",    1, 5, 1, 0, 0, 0, 0, 0, 8'hA5, 8'hFF);
    step("R9 forbid over pgo",  1, 7, 1, 0, 1, 7, 1, 1, 8'hA5, 8'h0F);
    step("R9 read keeps old",   1, 5, 0, 0, 0, 0, 0, 0, 8'h96, 8'h00);
    for (int i = 0; i < 400; i++) begin
      step("R2 random", 1'($urandom), int'($urandom % 8), 1'($urandom),
           1'($urandom), 1'($urandom), int'($urandom % 8), 1'($urandom),
           1'($urandom), 8'($urandom), 8'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule